// File: doc/BRIEF.md
# Write-Only Serial Control Receiver

This block is a two-wire serial bus target that only receives. A system clock oversamples the bus clock and data lines. The block finds the bus start and stop conditions and shifts in address and data bits, most significant bit first. It answers each accepted byte by pulling the data line low through an open-drain enable during the acknowledge clock.

Only one transfer type is accepted: a write addressed to the block's own fixed 7-bit address. After the address byte, any number of command bytes may follow until a stop. The block hands each byte to a downstream command decoder with a one-cycle strobe. No register-address byte is used: every byte carries its own meaning. Reads, clock stretching, general call and 10-bit addressing are not supported.

The system clock must run at least 16 times faster than the bus clock. The bus clock runs at up to 100 kbit/s.

Top module: `i2c_wr_slave`

## Requirements
- R1: After reset, `sda_pull_o`, `busy_o` and `byte_vld_o` are all low.
- R2: A START is SDA falling while SCL is high, and it begins reception of an address byte. A STOP is SDA rising while SCL is high. After a STOP, `busy_o` is low and no byte is strobed until the next START.
- R3: An address byte equal to `{DEV_ADDR, 1'b0}` (default 8'b1000_1000; the write bit is the last bit sent) is acknowledged. The block holds `sda_pull_o` high for the whole high phase of the ninth SCL clock.
- R4: When the address does not match, or the direction bit is 1, the block gives no acknowledge. It keeps SDA released, does not raise `busy_o`, strobes no bytes, and ignores all bits until the next START or STOP.
- R5: Each data byte is sampled MSB first on SCL high and appears on `byte_o` together with a strobe on `byte_vld_o` that lasts exactly one system clock. The strobe comes after the eighth bit is sampled and before the ninth SCL clock rises.
- R6: Every data byte after a matching address is acknowledged in the same way as the address. `sda_pull_o` is only raised while SCL is low.
- R7: A matching address may be followed by zero or more data bytes. A transfer with no data bytes produces no strobe.
- R8: A repeated START in the middle of a byte or a transfer drops the partial byte, resets the bit count and expects a new address byte.
- R9: `busy_o` rises when a matching address byte has been fully received. It stays high until the next STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| sda_pull_o | output | 1 | Open-drain enable; 1 drives the data line low |
| byte_vld_o | output | 1 | One-clock strobe for a received data byte |
| byte_o | output | 8 | Received data byte, valid with the strobe |
| busy_o | output | 1 | Addressed write transfer in progress |

## Verification
The bench builds the block with its default parameters: the default device address and a two-flop synchronizer. It runs the bus at 32 system clocks per bit, twice the minimum oversampling ratio, so the full synchronizer and edge-detector latency sits well inside each SCL phase. With these values the bench can reach the address comparison against both a neighbouring address and the read direction. It can also exercise repeated starts that cut a byte short, and confirm that every strobe comes before the acknowledge clock.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
        logic scl;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [ADDR_W-1:0] own);
        return b == {own, 1'b0};
    endfunction

endpackage

// File: rtl/i2c_sync_cell.sv
module i2c_sync_cell #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [1:0] line_raw;
    logic [1:0] line_s;
    logic       scl_q, sda_q;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_sync_cell #(.STAGES(SYNC_STAGES)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .din  (line_raw[g]),
            .dout (line_s[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= line_s[1];
            sda_q <= line_s[0];
        end
    end

    always_comb begin
        evt.scl      = line_s[1];
        evt.sda      = line_s[0];
        evt.scl_rise = line_s[1] & ~scl_q;
        evt.scl_fall = ~line_s[1] & scl_q;
        evt.start    = line_s[1] & scl_q & sda_q & ~line_s[0];
        evt.stop     = line_s[1] & scl_q & ~sda_q & line_s[0];
    end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b1000100
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    output logic              sda_pull,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic              busy
);
    rx_state_e         state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] byte_now;
    logic              last_bit;

    assign byte_now = {shreg[BYTE_W-2:0], evt.sda};
    assign last_bit = (bitcnt == CNT_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            byte_vld <= 1'b0;
            byte_out <= '0;
            busy     <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (evt.start) begin
                state    <= ST_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                busy     <= 1'b0;
            end else if (evt.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                busy     <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_DATA: begin
                        if (evt.scl_rise) begin
                            shreg <= byte_now;
                            if (last_bit) begin
                                bitcnt <= '0;
                                if (state == ST_ADDR) begin
                                    if (addr_hit(byte_now, DEV_ADDR)) begin
                                        state <= ST_ACK_SETUP;
                                        busy  <= 1'b1;
                                    end else begin
                                        state <= ST_SKIP;
                                    end
                                end else begin
                                    byte_vld <= 1'b1;
                                    byte_out <= byte_now;
                                    state    <= ST_ACK_SETUP;
                                end
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_ACK_SETUP: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b1;
                            state    <= ST_ACK_HOLD;
                        end
                    end
                    ST_ACK_HOLD: begin
                        if (evt.scl_fall) begin
                            sda_pull <= 1'b0;
                            bitcnt   <= '0;
                            state    <= ST_DATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave
    import i2c_wr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'b1000100,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              busy_o
);
    bus_evt_t evt;

    i2c_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_rx_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .sda_pull (sda_pull_o),
        .byte_vld (byte_vld_o),
        .byte_out (byte_o),
        .busy     (busy_o)
    );
endmodule

// File: rtl/i2c_wr_slave_chk.sv
module i2c_wr_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_s,
    input logic stop_det,
    input logic start_det,
    input logic sda_pull_o,
    input logic byte_vld_o,
    input logic busy_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        (!rst && $past(rst)) |-> (!sda_pull_o && !busy_o && !byte_vld_o));

    assert_stop_idles_R2: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !busy_o);

    assert_ack_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
        sda_pull_o |-> busy_o);

    assert_strobe_only_busy_R4: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> busy_o);

    assert_strobe_one_clk_R5: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);

    assert_pull_on_low_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !$past(scl_s));

    assert_restart_drops_R8: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (!busy_o && !sda_pull_o));
endmodule

bind i2c_wr_slave i2c_wr_slave_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (evt.scl),
    .stop_det   (evt.stop),
    .start_det  (evt.start),
    .sda_pull_o (sda_pull_o),
    .byte_vld_o (byte_vld_o),
    .busy_o     (busy_o)
);

// File: tb/i2c_wr_slave_tb.sv
module i2c_wr_slave_tb;
    localparam int Q    = 8;
    localparam int HALF = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull_o, byte_vld_o, busy_o;
    logic [7:0] byte_o;
    logic       sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;

    i2c_wr_slave u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull_o),
        .byte_vld_o (byte_vld_o),
        .byte_o     (byte_o),
        .busy_o     (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        if (scl_m == 1'b0) begin
            tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
        end
        tick(HALF); sda_m = 1'b0; tick(HALF); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1;
        tick(HALF); sda_m = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(input bit b);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1; tick(HALF); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit want_ack, input bit is_data,
                             input string req);
        logic a0, a1;
        if (is_data && want_ack) exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(Q); sda_m = 1'b1; tick(Q); scl_m = 1'b1;
        tick(2); a0 = sda_line; tick(HALF - 4); a1 = sda_line; tick(2);
        if (is_data && want_ack)
            check(exp_q.size() == 0, "R5 strobe before ack clock", exp_q.size(), 0);
        if (want_ack) check(!a0 && !a1, req, {a0, a1}, 0);
        else          check(a0 && a1, req, {a0, a1}, 3);
        scl_m = 1'b0;
    endtask

    // monitor: pops expected bytes as strobes appear
    always @(negedge clk) begin
        if (!rst && byte_vld_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4/R7 unexpected strobe", byte_o, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(byte_o == e, "R5 byte value", byte_o, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        check(!sda_pull_o && !busy_o && !byte_vld_o, "R1 reset state",
              {sda_pull_o, busy_o, byte_vld_o}, 0);

        // stream of data bytes, MSB first
        bus_start();
        send_byte(8'h88, 1, 0, "R3 address ack");
        check(busy_o == 1'b1, "R9 busy after match", busy_o, 1);
        send_byte(8'hA5, 1, 1, "R6 data ack");
        send_byte(8'h00, 1, 1, "R6 data ack 00");
        send_byte(8'hFF, 1, 1, "R6 data ack FF");
        send_byte(8'h80, 1, 1, "R6 data ack 80");
        send_byte(8'h01, 1, 1, "R6 data ack 01");
        bus_stop();
        tick(4);
        check(busy_o == 1'b0, "R2 busy cleared by stop", busy_o, 0);

        // zero data bytes
        bus_start();
        send_byte(8'h88, 1, 0, "R7 address ack, no data");
        bus_stop();
        tick(4);
        check(busy_o == 1'b0 && exp_q.size() == 0, "R7 empty transfer", busy_o, 0);

        // neighbouring address: ignored
        bus_start();
        send_byte(8'h8A, 0, 0, "R4 no ack on mismatch");
        check(busy_o == 1'b0, "R4 busy stays low", busy_o, 0);
        send_byte(8'h5A, 0, 0, "R4 data ignored");
        bus_stop();

        // read direction: ignored
        bus_start();
        send_byte(8'h89, 0, 0, "R4 no ack on read bit");
        send_byte(8'hC3, 0, 0, "R4 data ignored after read");
        check(busy_o == 1'b0, "R4 busy low after read", busy_o, 0);
        bus_stop();

        // repeated start cutting a byte short
        bus_start();
        send_byte(8'h88, 1, 0, "R8 first address ack");
        send_byte(8'h11, 1, 1, "R8 byte before restart");
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_start();
        check(busy_o == 1'b0, "R8 restart clears busy", busy_o, 0);
        send_byte(8'h88, 1, 0, "R8 new address ack");
        send_byte(8'h22, 1, 1, "R8 byte after restart");
        // restart to a foreign address
        bus_start();
        send_byte(8'h10, 0, 0, "R8 restart to foreign address");
        check(busy_o == 1'b0, "R8 busy low after foreign restart", busy_o, 0);
        bus_stop();

        // after stop, address with no start is ignored
        send_byte(8'h88, 0, 0, "R2 no start, no ack");

        tick(10);
        check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule